// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host and an asynchronous, 4-bit-wide fast page mode DRAM. It drives the RAS, CAS, WE and OE strobes and an 11-bit multiplexed address bus. Each host request names a 22-bit word. The upper 11 bits select the row and the lower 11 bits select the column. Every strobe timing limit is a parameter counted in controller clock cycles.

Once a row is opened it stays open. A later request to the same row is served as a CAS-only page cycle. A request to another row first closes the current row, waits out the precharge and then opens the new row. The row is also closed when it nears the maximum RAS-low time. Writes use the early-write form: WE and the data are in place before CAS falls, and OE stays high. Reads wait until all three access-time budgets have elapsed before the data pins are sampled. An external refresh agent uses a request/grant pair. The controller answers a refresh request by finishing its column cycle, closing the row, precharging and then granting.

Top module: `fpm_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, RAS, CAS, WE and OE are high (inactive), the data pins are not driven, and `rd_valid` and `ref_gnt` are low.
- R2: When RAS falls, the address pins carry request bits [21:11] (the row). When CAS falls, they carry request bits [10:0] (the column).
- R3: CAS falls at least `T_RCD` cycles after the RAS fall that opened the row.
- R4: RAS stays high for at least `T_RP` cycles before each fall. This also holds for the first fall after reset.
- R5: RAS stays low for at least `T_RAS` cycles and never more than `T_RAS_MAX` cycles. The row is closed even when row hits keep arriving.
- R6: Each CAS low pulse lasts at least `T_CAS` cycles. CAS stays high at least `T_CP` cycles between column cycles. Within one row, successive CAS falls are at least `T_PC` cycles apart.
- R7: For a write, WE goes low and the data pins are driven (enable high) at least one cycle before CAS falls, with OE high. The data stays driven while CAS is low.
- R8: For a read, WE is high, OE is low and the pins are not driven. The data is sampled on the edge where CAS has been low `T_CAC` cycles, the column has been on the pins `T_AA` cycles and RAS has been low `T_RAC` cycles, whichever is latest. It is returned on `rd_data` with a one-cycle `rd_valid`, in request order.
- R9: A request to the open row is accepted and served without any RAS transition.
- R10: A request to a different row causes RAS to rise, a full precharge, and a new RAS fall carrying the new row.
- R11: On `ref_req`, the controller finishes the current column cycle, raises RAS and waits `T_RP` cycles, then asserts `ref_gnt`. While granted, the strobes stay high and no request is accepted. `ref_gnt` drops on the edge after `ref_req` drops, and a full precharge follows before the next activation.
- R12: CAS is low only while RAS is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 22 | Word address, row in [21:11], column in [10:0] |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle strobe for returned read data |
| rd_data | output | 4 | Read data |
| ref_req | input | 1 | Refresh agent wants the memory |
| ref_gnt | output | 1 | Memory is precharged and handed to the refresh agent |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 4 | Data driven toward the memory |
| dram_dq_oe | output | 1 | Drive enable for the data pins |
| dram_dq_in | input | 4 | Data from the memory |

## Verification
The bench connects a memory model that returns the inverted word until each of the three access budgets is met. A controller that samples one edge early therefore returns wrong data, and a model that wrote on the wrong column or row would fail the later sweeps. The model also times every strobe edge in cycles. It catches a CAS fall that comes too soon after RAS, a short precharge, or a RAS-low stretch that runs past the limit during an unbroken run of row hits, as a controller that forgot the ceiling would do. Counting RAS falls shows whether hits reopen the row and whether misses skip the close. The refresh sequence checks that the grant waits for precharge and that requests offered while it is held are refused.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    S_PRE,   // RAS high, precharge dwell
    S_IDLE,  // no row open, precharge met
    S_ROW,   // row on pins, RAS about to fall
    S_RCD,   // RAS low, waiting before column
    S_COL,   // column and write data on pins
    S_CASL,  // CAS low
    S_CASH,  // CAS high, row open
    S_REF    // memory handed to refresh agent
  } fpm_state_t;
endpackage

// File: rtl/fpm_dwell.sv
module fpm_dwell #(
  parameter int W       = 4,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= W'(RST_VAL);
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/fpm_age.sv
module fpm_age #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  output logic [W-1:0] age
);
  // age = cycles from the start edge to the next edge; saturates ("long ago")
  always_ff @(posedge clk) begin
    if (rst)              age <= '1;
    else if (start)       age <= W'(1);
    else if (age != '1)   age <= age + W'(1);
  end
endmodule

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
#(
  parameter int ROW_W     = 11,
  parameter int COL_W     = 11,
  parameter int DQ_W      = 4,
  parameter int T_RP      = 4,
  parameter int T_RCD     = 2,
  parameter int T_RAS     = 6,
  parameter int T_RAS_MAX = 9900,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 1,
  parameter int T_PC      = 4,
  parameter int T_CAC     = 2,
  parameter int T_AA      = 3,
  parameter int T_RAC     = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_we,
  input  logic [DQ_W-1:0]        req_wdata,
  output logic                   rd_valid,
  output logic [DQ_W-1:0]        rd_data,
  input  logic                   ref_req,
  output logic                   ref_gnt,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [ROW_W-1:0]       dram_addr,
  output logic [DQ_W-1:0]        dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DQ_W-1:0]        dram_dq_in
);
  localparam int AW     = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int GUARD  = T_CAS + T_CAC + T_AA + T_RAC + T_CP + T_PC + 2;
  localparam int LIMIT  = T_RAS_MAX - GUARD;
  localparam int AGE_W  = $clog2(T_RAS_MAX + 1) + 1;
  localparam int TMR_W  = $clog2(T_RP + T_RCD + T_CP + 1);
  localparam logic [AGE_W-1:0] A_LIM = AGE_W'(LIMIT);
  localparam logic [AGE_W-1:0] A_RAS = AGE_W'(T_RAS);
  localparam logic [AGE_W-1:0] A_CAS = AGE_W'(T_CAS);
  localparam logic [AGE_W-1:0] A_CAC = AGE_W'(T_CAC);
  localparam logic [AGE_W-1:0] A_AA  = AGE_W'(T_AA - 1);
  localparam logic [AGE_W-1:0] A_RAC = AGE_W'(T_RAC);
  localparam logic [AGE_W-1:0] A_PC  = AGE_W'(T_PC - 1);

  fpm_state_t state;
  logic [ROW_W-1:0] open_row;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic [DQ_W-1:0]  wd_q;
  logic [AGE_W-1:0] ras_age, cas_age;
  logic             tmr_done, tmr_load;
  logic [TMR_W-1:0] tmr_val;

  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  assign req_row = req_addr[ROW_W+COL_W-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];

  // timing qualifiers, each referring to the next clock edge
  logic hit, ras_ok, near_lim, pc_ok, rd_ok;
  assign hit      = (req_row == open_row);
  assign ras_ok   = (ras_age >= A_RAS);
  assign near_lim = (ras_age >= A_LIM);
  assign pc_ok    = (cas_age >= A_PC);
  assign rd_ok    = (cas_age >= A_CAC) && (cas_age >= A_AA) && (ras_age >= A_RAC);

  logic page_ok, casl_done, close_now, ref_exit, pre_go, rcd_go, accept;
  assign page_ok   = (state == S_CASH) && tmr_done && pc_ok && !near_lim && hit;
  assign req_ready = !ref_req && ((state == S_IDLE) || page_ok);
  assign accept    = req_valid && req_ready;
  assign casl_done = (state == S_CASL) && (cas_age >= A_CAS) && (wr_q || rd_ok);
  assign close_now = (state == S_CASH) && tmr_done && ras_ok &&
                     (ref_req || near_lim || (req_valid && !hit));
  assign ref_exit  = (state == S_REF) && !ref_req;
  assign pre_go    = close_now || ref_exit;
  assign rcd_go    = (state == S_ROW);

  assign tmr_load = pre_go || rcd_go || casl_done;
  always_comb begin
    if (pre_go)      tmr_val = TMR_W'(T_RP - 1);
    else if (rcd_go) tmr_val = TMR_W'(T_RCD - 1);
    else             tmr_val = TMR_W'(T_CP - 1);
  end

  fpm_dwell #(.W(TMR_W), .RST_VAL(T_RP - 1)) u_dwell (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );
  fpm_age #(.W(AGE_W)) u_ras_age (
    .clk(clk), .rst(rst), .start(rcd_go), .age(ras_age)
  );
  fpm_age #(.W(AGE_W)) u_cas_age (
    .clk(clk), .rst(rst), .start(state == S_COL), .age(cas_age)
  );

  // column source: a page hit takes the live request, otherwise the latched one
  logic [COL_W-1:0] col_src;
  logic             wr_src;
  logic [DQ_W-1:0]  wd_src;
  assign col_src = (state == S_CASH) ? req_col   : col_q;
  assign wr_src  = (state == S_CASH) ? req_we    : wr_q;
  assign wd_src  = (state == S_CASH) ? req_wdata : wd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_PRE;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_oe  <= 1'b0;
      dram_dq_out <= '0;
      dram_addr   <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      ref_gnt     <= 1'b0;
      open_row    <= '0;
      col_q       <= '0;
      wr_q        <= 1'b0;
      wd_q        <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (accept) begin
        col_q <= req_col;
        wr_q  <= req_we;
        wd_q  <= req_wdata;
      end
      case (state)
        S_PRE: if (tmr_done) begin
          state   <= ref_req ? S_REF : S_IDLE;
          ref_gnt <= ref_req;
        end
        S_IDLE: if (ref_req) begin
          state   <= S_REF;
          ref_gnt <= 1'b1;
        end else if (req_valid) begin
          state     <= S_ROW;
          dram_addr <= AW'(req_row);
          open_row  <= req_row;
        end
        S_ROW: begin
          dram_ras_n <= 1'b0;
          state      <= S_RCD;
        end
        S_CASL: if (casl_done) begin
          dram_cas_n <= 1'b1;
          dram_we_n  <= 1'b1;
          dram_oe_n  <= 1'b1;
          dram_dq_oe <= 1'b0;
          rd_valid   <= !wr_q;
          rd_data    <= dram_dq_in;
          state      <= S_CASH;
        end
        S_COL: begin
          dram_cas_n <= 1'b0;
          state      <= S_CASL;
        end
        S_REF: if (ref_exit) begin
          ref_gnt <= 1'b0;
          state   <= S_PRE;
        end
        default: ;
      endcase
      if (close_now) begin
        dram_ras_n <= 1'b1;
        state      <= S_PRE;
      end else if ((state == S_RCD && tmr_done) || (page_ok && req_valid)) begin
        dram_addr   <= AW'(col_src);
        dram_we_n   <= !wr_src;
        dram_oe_n   <= wr_src;
        dram_dq_oe  <= wr_src;
        dram_dq_out <= wd_src;
        state       <= S_COL;
      end
    end
  end
endmodule

// File: rtl/fpm_ctrl_chk.sv
module fpm_ctrl_chk #(
  parameter int T_RP      = 4,
  parameter int T_CAS     = 2,
  parameter int T_RAS_MAX = 9900
) (
  input logic clk,
  input logic rst,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic rd_valid,
  input logic ref_gnt,
  input logic req_ready
);
  logic [31:0] lo_cnt, hi_cnt, cas_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
      cas_lo <= '0;
    end else begin
      lo_cnt <= ras_n ? '0 : lo_cnt + 32'd1;
      hi_cnt <= ras_n ? hi_cnt + 32'd1 : '0;
      cas_lo <= cas_n ? '0 : cas_lo + 32'd1;
    end
  end

  a_r12_cas_inside_ras: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n);
  a_r7_we_before_cas: assert property (@(posedge clk) disable iff (rst)
    ($fell(cas_n) && !we_n) |-> $past(!we_n));
  a_r7_drive_only_write: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (oe_n && !we_n));
  a_r8_data_at_cas_rise: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $rose(cas_n));
  a_r11_grant_quiet: assert property (@(posedge clk) disable iff (rst)
    ref_gnt |-> (ras_n && cas_n && !req_ready));
  a_r5_ras_ceiling: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> (lo_cnt < 32'(T_RAS_MAX)));
  a_r4_precharge: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (hi_cnt >= 32'(T_RP)));
  a_r6_cas_width: assert property (@(posedge clk) disable iff (rst)
    $rose(cas_n) |-> (cas_lo >= 32'(T_CAS)));
endmodule

bind fpm_ctrl fpm_ctrl_chk #(
  .T_RP(T_RP), .T_CAS(T_CAS), .T_RAS_MAX(T_RAS_MAX)
) u_chk (
  .clk(clk), .rst(rst), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_oe(dram_dq_oe),
  .rd_valid(rd_valid), .ref_gnt(ref_gnt), .req_ready(req_ready)
);

// File: tb/fpm_ctrl_tb.sv
module fpm_ctrl_tb;
  localparam int T_RP = 4, T_RCD = 2, T_RAS = 6, T_RAS_MAX = 60;
  localparam int T_CAS = 2, T_CP = 1, T_PC = 4, T_CAC = 2, T_AA = 3, T_RAC = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0, dram_dq_in = '0;
  logic        req_ready, rd_valid, ref_gnt;
  logic [3:0]  rd_data, dram_dq_out;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [10:0] dram_addr;

  fpm_ctrl #(.T_RP(T_RP), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RAS_MAX(T_RAS_MAX),
             .T_CAS(T_CAS), .T_CP(T_CP), .T_PC(T_PC), .T_CAC(T_CAC),
             .T_AA(T_AA), .T_RAC(T_RAC)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) cyc++;

  // memory model: 256 words indexed by row[2:0], col[4:0]
  logic [3:0]  mem [256];
  logic [3:0]  shadow [256];
  logic [21:0] addrq [$];
  logic [3:0]  expq [$];
  int ras_fall_c = -1000, ras_rise_c = 0, cas_fall_c = -1000, cas_rise_c = -1000;
  int we_fall_c = -1000, col_chg_c = -1000, ras_falls = 0, cas_falls = 0;
  logic [10:0] row_lat = '0;
  logic [7:0]  cur_idx = '0;

  function automatic logic [7:0] idx_of(input logic [21:0] a);
    return {a[13:11], a[4:0]};
  endfunction

  function automatic logic [21:0] mk(input int r, input int c);
    logic [7:0] rh = 8'(r * 91);
    logic [5:0] ch = 6'(c * 21);
    return {rh, 3'(r), ch, 5'(c)};
  endfunction

  always @(negedge dram_ras_n) if (!rst) begin
    chk(cyc - ras_rise_c >= T_RP, "R4 precharge", cyc - ras_rise_c, T_RP);
    ras_fall_c = cyc;
    ras_falls++;
    row_lat = dram_addr;
  end

  always @(posedge dram_ras_n) if (!rst) begin
    if (ras_fall_c >= 0) begin
      chk(cyc - ras_fall_c >= T_RAS, "R5 ras min", cyc - ras_fall_c, T_RAS);
      chk(cyc - ras_fall_c <= T_RAS_MAX, "R5 ras max", cyc - ras_fall_c, T_RAS_MAX);
    end
    ras_rise_c = cyc;
  end

  always @(negedge dram_we_n) we_fall_c = cyc;
  always @(dram_addr) col_chg_c = cyc;

  always @(negedge dram_cas_n) if (!rst) begin
    logic [21:0] ea;
    cas_falls++;
    chk(!dram_ras_n, "R12 cas under ras", dram_ras_n, 0);
    chk(cyc - ras_fall_c >= T_RCD, "R3 ras-to-cas", cyc - ras_fall_c, T_RCD);
    chk(cyc - cas_rise_c >= T_CP, "R6 cas precharge", cyc - cas_rise_c, T_CP);
    if (cas_fall_c > ras_fall_c)
      chk(cyc - cas_fall_c >= T_PC, "R6 page cycle", cyc - cas_fall_c, T_PC);
    if (addrq.size() == 0) begin
      chk(1'b0, "R2 unexpected column cycle", 1, 0);
      ea = '0;
    end else ea = addrq.pop_front();
    chk(row_lat == ea[21:11], "R2 row", int'(row_lat), int'(ea[21:11]));
    chk(dram_addr == ea[10:0], "R2 column", int'(dram_addr), int'(ea[10:0]));
    cur_idx = {row_lat[2:0], dram_addr[4:0]};
    if (!dram_we_n) begin
      chk(cyc - we_fall_c >= 1, "R7 we setup", cyc - we_fall_c, 1);
      chk(dram_dq_oe && dram_oe_n, "R7 drive/oe", {dram_dq_oe, dram_oe_n}, 3);
      mem[cur_idx] = dram_dq_out;
    end else begin
      chk(!dram_oe_n && !dram_dq_oe, "R8 read strobes", {dram_oe_n, dram_dq_oe}, 0);
    end
    cas_fall_c = cyc;
  end

  always @(posedge dram_cas_n) if (!rst) begin
    chk(cyc - cas_fall_c >= T_CAS, "R6 cas width", cyc - cas_fall_c, T_CAS);
    cas_rise_c = cyc;
  end

  // data valid only once all three access budgets are met at the coming edge
  always @(negedge clk) begin
    bit ok;
    ok = !dram_cas_n && dram_we_n &&
         (cyc + 1 - cas_fall_c >= T_CAC) && (cyc + 1 - col_chg_c >= T_AA) &&
         (cyc + 1 - ras_fall_c >= T_RAC);
    dram_dq_in <= ok ? mem[cur_idx] : ~mem[cur_idx];
  end

  always @(negedge clk) if (!rst && rd_valid) begin
    if (expq.size() == 0) chk(1'b0, "R8 unexpected rd_valid", 1, 0);
    else begin
      logic [3:0] e;
      e = expq.pop_front();
      chk(rd_data == e, "R8 read data", rd_data, e);
    end
  end

  task automatic send(input logic [21:0] a, input logic w, input logic [3:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = w; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    addrq.push_back(a);
    if (w) shadow[idx_of(a)] = d;
    else   expq.push_back(shadow[idx_of(a)]);
  endtask

  task automatic drain();
    int k = 0;
    while ((expq.size() != 0 || addrq.size() != 0) && k < 200) begin
      @(negedge clk); k++;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 4'(i ^ (i >> 4));
      shadow[i] = mem[i];
    end
    repeat (5) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes in reset",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
    rst = 1'b0;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
    chk(!dram_dq_oe && !rd_valid && !ref_gnt, "R1 idle outputs",
        {dram_dq_oe, rd_valid, ref_gnt}, 0);

    // R9: one activation serves a run of row hits
    base = ras_falls;
    send(mk(0, 0), 1'b0, 4'h0);
    for (int c = 1; c < 4; c++) send(mk(0, c), 1'b1, 4'(c + 9));
    send(mk(0, 2), 1'b0, 4'h0);
    drain();
    chk(ras_falls - base == 1, "R9 row hits without reopen", ras_falls - base, 1);

    // R10: each row change reopens the row
    base = ras_falls;
    send(mk(1, 0), 1'b0, 4'h0);
    send(mk(2, 0), 1'b0, 4'h0);
    send(mk(1, 1), 1'b0, 4'h0);
    drain();
    chk(ras_falls - base == 3, "R10 row misses", ras_falls - base, 3);

    // sweep: write every word row-major, read back row-major and column-major
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 32; c++) send(mk(r, c), 1'b1, 4'(r * 5 + c * 3 + 1));
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 32; c++) send(mk(r, c), 1'b0, 4'h0);
    for (int c = 0; c < 32; c++)
      for (int r = 0; r < 8; r++) send(mk(r, c), 1'b0, 4'h0);
    drain();

    // R5: an unbroken run of hits must still be closed by the ceiling
    base = ras_falls;
    for (int k = 0; k < 40; k++) send(mk(5, k % 32), 1'b0, 4'h0);
    drain();
    chk(ras_falls - base >= 2, "R5 row closed during hits", ras_falls - base, 2);

    // R11: refresh with an open row
    send(mk(3, 3), 1'b0, 4'h0);
    drain();
    @(negedge clk);
    ref_req = 1'b1;
    begin
      int k = 0;
      while (!ref_gnt && k < 100) begin @(negedge clk); k++; end
      chk(ref_gnt, "R11 grant given", ref_gnt, 1);
      chk(dram_ras_n && dram_cas_n, "R11 strobes at grant", {dram_ras_n, dram_cas_n}, 3);
      chk(cyc - ras_rise_c >= T_RP, "R11 precharge before grant", cyc - ras_rise_c, T_RP);
    end
    base = cas_falls;
    req_valid = 1'b1; req_addr = mk(3, 4); req_we = 1'b0;
    repeat (8) begin
      @(negedge clk); #1;
      chk(ref_gnt && dram_ras_n && !req_ready, "R11 held grant refuses requests",
          {ref_gnt, dram_ras_n, req_ready}, 6);
    end
    chk(cas_falls == base, "R11 no column cycle while granted", cas_falls - base, 0);
    req_valid = 1'b0;
    @(negedge clk);
    ref_req = 1'b0;
    @(negedge clk);
    chk(!ref_gnt, "R11 grant released", ref_gnt, 0);
    send(mk(3, 3), 1'b0, 4'h0);
    send(mk(3, 4), 1'b0, 4'h0);
    drain();

    // interleaved write/read across alternating rows
    for (int k = 0; k < 32; k++) begin
      send(mk(k % 8, (k * 7) % 32), 1'b1, 4'(15 - k % 16));
      send(mk(k % 8, (k * 7) % 32), 1'b0, 4'h0);
      send(mk((k + 3) % 8, k), 1'b0, 4'h0);
    end
    drain();
    chk(expq.size() == 0, "R8 all reads returned", expq.size(), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule